// File: doc/BRIEF.md
# Split-Mode Second Timer

This block is the second timer/counter of a small 8-bit controller. It holds a high count byte and a low count byte. It advances them on machine-cycle strobes, or on rising edges of an external count pin. It reports an overflow both as a sticky flag, which feeds the interrupt logic, and as a one-clock pulse, which feeds the serial-port baud generator.

Its own two-bit mode field selects one of four modes:

- a 13-bit counter;
- a 16-bit counter;
- an 8-bit counter that reloads itself;
- a hold mode.

A gate bit ties counting to an external interrupt input. A select bit swaps machine cycles for pin edges.

The first timer's mode field is also an input. When it reads 3, the first timer has borrowed this timer's controls. In that case this timer counts every machine cycle, whatever its run, gate and select bits say. Its overflows still clock the baud generator, but they never set the flag. Software can load either count byte. Software can clear the flag, and the interrupt acknowledge also clears it.

Top module: `t1_split_timer`

## Requirements
- R1: With `t1_mode` = 0, the count is 13 bits: `th_o` is bits 12..5 and `tl_o[4:0]` is bits 4..0. A carry out of bit 12 wraps the count to zero and is an overflow. `tl_o[7:5]` keep their value.
- R2: With `t1_mode` = 1, `th_o` and `tl_o` form a 16-bit count with `th_o` as the upper byte. Stepping from 16'hFFFF gives 16'h0000 and an overflow.
- R3: With `t1_mode` = 2, only `tl_o` counts. Stepping from 8'hFF loads `tl_o` from `th_o` and is an overflow. `th_o` never changes on its own in this mode.
- R4: With `t1_mode` = 3, both count bytes hold their value, whatever the other controls say.
- R5: When the first timer is not split, the count advances by at most one per clock, only in a clock where `mc_tick` is 1, and only while `t1_run` is 1. When `t1_cnt_sel` = 0, each such strobe advances it by one.
- R6: When the first timer is not split, `t1_gate` = 1 together with `gate_in` = 0 blocks counting. `t1_gate` = 1 together with `gate_in` = 1 lets counting proceed.
- R7: With `t1_cnt_sel` = 1, the count source is rising edges of `cnt_pin`, seen through a two-flop synchroniser. Each `mc_tick` consumes the pending edge, so there is at most one step per strobe however many edges arrived. A strobe with no edge pending leaves the count alone.
- R8: An overflow raises `baud_pulse_o` for exactly the one clock after the strobe that caused it. Outside split mode, it also sets `ovf_flag_o` in that clock.
- R9: `ovf_flag_o` is cleared one clock after `flag_clr` or `irq_ack`. An overflow in the same clock wins, and the flag stays set.
- R10: When `t0_mode` = 3, `t1_run`, `t1_gate` and `t1_cnt_sel` are ignored and the count steps on every `mc_tick`. An overflow in this state pulses `baud_pulse_o` but never sets `ovf_flag_o`.
- R11: A clock with `wr_th` or `wr_tl` loads `wr_data` into that byte, which is visible on the next clock.
- R12: After reset, both count bytes, `ovf_flag_o` and `baud_pulse_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin | input | 1 | External count pin, asynchronous |
| gate_in | input | 1 | External interrupt level used for gating (1 = active) |
| t0_mode | input | 2 | First timer's mode field, value 3 = split |
| t1_mode | input | 2 | This timer's mode (0 13-bit, 1 16-bit, 2 reload, 3 hold) |
| t1_gate | input | 1 | Gate enable |
| t1_cnt_sel | input | 1 | 1 = count pin edges, 0 = count machine cycles |
| t1_run | input | 1 | Run control |
| wr_th | input | 1 | Load high byte from `wr_data` |
| wr_tl | input | 1 | Load low byte from `wr_data` |
| wr_data | input | 8 | Load value |
| flag_clr | input | 1 | Software clear of the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| th_o | output | 8 | High count byte |
| tl_o | output | 8 | Low count byte |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| baud_pulse_o | output | 1 | One-clock overflow pulse to the baud generator |

## Verification
The stability properties assume that a clock carrying a byte write is excluded from the window, since a load may change a byte at any time. They also assume that the only thing able to set the flag is an overflow. The pin-edge property assumes each `cnt_pin` level lasts at least two clocks, so the synchroniser cannot drop a pulse. The stimulus therefore changes mode, gate and select fields only between strobes, keeps pin pulses three clocks wide, and pulses `mc_tick` for a single clock with idle clocks around it.

// File: rtl/t1s_pkg.sv
package t1s_pkg;
    parameter int unsigned BYTE_W  = 8;
    parameter int unsigned PRESC_W = 5;
    parameter logic [1:0]  T0_SPLIT = 2'd3;

    typedef enum logic [1:0] {
        MODE_13B    = 2'd0,
        MODE_16B    = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_HOLD   = 2'd3
    } tmode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] th;
        logic [BYTE_W-1:0] tl;
        logic              flag;
        logic              baud;
    } tstate_t;
endpackage

// File: rtl/t1s_edge_unit.sv
module t1s_edge_unit #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic consume_i,
    output logic evt_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   pend;
    } est_t;

    est_t est_d, est_q;
    logic rise;

    always_comb begin
        rise         = est_q.sync[SYNC_STAGES-1] & ~est_q.prev;
        evt_o        = est_q.pend | rise;
        est_d        = est_q;
        est_d.sync   = {est_q.sync[SYNC_STAGES-2:0], pin_i};
        est_d.prev   = est_q.sync[SYNC_STAGES-1];
        // a strobe takes whatever is pending; extra edges before it merge
        est_d.pend   = consume_i ? 1'b0 : (est_q.pend | rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) est_q <= '0;
        else        est_q <= est_d;
    end
endmodule

// File: rtl/t1s_gate_unit.sv
module t1s_gate_unit
    import t1s_pkg::*;
(
    input  logic [1:0] t0_mode,
    input  tmode_e     mode,
    input  logic       run,
    input  logic       gate,
    input  logic       gate_in,
    input  logic       cnt_sel,
    input  logic       mc_tick,
    input  logic       pin_evt,
    output logic       inc_o,
    output logic       split_o
);
    always_comb begin
        split_o = (t0_mode == T0_SPLIT);
        if (mode == MODE_HOLD) begin
            inc_o = 1'b0;
        end else if (split_o) begin
            // controls are on loan to the first timer: plain cycle count
            inc_o = mc_tick;
        end else begin
            inc_o = mc_tick & run & ~(gate & ~gate_in) & (cnt_sel ? pin_evt : 1'b1);
        end
    end
endmodule

// File: rtl/t1s_incr_unit.sv
module t1s_incr_unit
    import t1s_pkg::*;
(
    input  tmode_e            mode,
    input  logic              inc,
    input  logic [BYTE_W-1:0] th_i,
    input  logic [BYTE_W-1:0] tl_i,
    output logic [BYTE_W-1:0] th_o,
    output logic [BYTE_W-1:0] tl_o,
    output logic              ovf_o
);
    localparam int unsigned W13 = BYTE_W + PRESC_W;
    localparam int unsigned W16 = 2 * BYTE_W;

    logic [W13:0]    s13;
    logic [W16:0]    s16;
    logic [BYTE_W:0] s8;

    always_comb begin
        s13   = {1'b0, th_i, tl_i[PRESC_W-1:0]} + (W13+1)'(1);
        s16   = {1'b0, th_i, tl_i} + (W16+1)'(1);
        s8    = {1'b0, tl_i} + (BYTE_W+1)'(1);
        th_o  = th_i;
        tl_o  = tl_i;
        ovf_o = 1'b0;
        if (inc) begin
            case (mode)
                MODE_13B: begin
                    th_o  = s13[W13-1:PRESC_W];
                    tl_o  = {tl_i[BYTE_W-1:PRESC_W], s13[PRESC_W-1:0]};
                    ovf_o = s13[W13];
                end
                MODE_16B: begin
                    th_o  = s16[W16-1:BYTE_W];
                    tl_o  = s16[BYTE_W-1:0];
                    ovf_o = s16[W16];
                end
                MODE_RELOAD: begin
                    tl_o  = s8[BYTE_W] ? th_i : s8[BYTE_W-1:0];
                    ovf_o = s8[BYTE_W];
                end
                default: begin
                    ovf_o = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/t1_split_timer.sv
module t1_split_timer
    import t1s_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              cnt_pin,
    input  logic              gate_in,
    input  logic [1:0]        t0_mode,
    input  logic [1:0]        t1_mode,
    input  logic              t1_gate,
    input  logic              t1_cnt_sel,
    input  logic              t1_run,
    input  logic              wr_th,
    input  logic              wr_tl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              irq_ack,
    output logic [BYTE_W-1:0] th_o,
    output logic [BYTE_W-1:0] tl_o,
    output logic              ovf_flag_o,
    output logic              baud_pulse_o
);
    tstate_t           st_d, st_q;
    tmode_e            mode;
    logic              pin_evt, inc, split, ovf;
    logic [BYTE_W-1:0] th_nx, tl_nx;

    assign mode = tmode_e'(t1_mode);

    t1s_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (cnt_pin),
        .consume_i (mc_tick),
        .evt_o     (pin_evt)
    );

    t1s_gate_unit i_gate (
        .t0_mode (t0_mode),
        .mode    (mode),
        .run     (t1_run),
        .gate    (t1_gate),
        .gate_in (gate_in),
        .cnt_sel (t1_cnt_sel),
        .mc_tick (mc_tick),
        .pin_evt (pin_evt),
        .inc_o   (inc),
        .split_o (split)
    );

    t1s_incr_unit i_incr (
        .mode  (mode),
        .inc   (inc),
        .th_i  (st_q.th),
        .tl_i  (st_q.tl),
        .th_o  (th_nx),
        .tl_o  (tl_nx),
        .ovf_o (ovf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.th   = wr_th ? wr_data : th_nx;
        st_d.tl   = wr_tl ? wr_data : tl_nx;
        st_d.baud = ovf;
        if (flag_clr || irq_ack) st_d.flag = 1'b0;
        if (ovf && !split)       st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign th_o         = st_q.th;
    assign tl_o         = st_q.tl;
    assign ovf_flag_o   = st_q.flag;
    assign baud_pulse_o = st_q.baud;
endmodule

// File: rtl/t1s_chk.sv
module t1s_chk
    import t1s_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mc_tick,
    input logic              gate_in,
    input logic [1:0]        t0_mode,
    input logic [1:0]        t1_mode,
    input logic              t1_gate,
    input logic              wr_th,
    input logic              wr_tl,
    input logic              flag_clr,
    input logic              irq_ack,
    input logic [BYTE_W-1:0] th_o,
    input logic [BYTE_W-1:0] tl_o,
    input logic              ovf_flag_o,
    input logic              baud_pulse_o
);
    a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !wr_th && !wr_tl) |=> ($stable(th_o) && $stable(tl_o)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_mode == 2'd3 && !wr_th && !wr_tl) |=> ($stable(th_o) && $stable(tl_o)));

    a_r3_th_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_mode == 2'd2 && !wr_th) |=> $stable(th_o));

    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_mode != T0_SPLIT && t1_gate && !gate_in && !wr_th && !wr_tl)
        |=> ($stable(th_o) && $stable(tl_o)));

    a_r10_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_mode == T0_SPLIT && !ovf_flag_o) |=> !ovf_flag_o);

    a_r8_baud_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse_o |-> $past(mc_tick));

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr || irq_ack) |=> (!ovf_flag_o || baud_pulse_o));
endmodule

bind t1_split_timer t1s_chk i_t1s_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mc_tick      (mc_tick),
    .gate_in      (gate_in),
    .t0_mode      (t0_mode),
    .t1_mode      (t1_mode),
    .t1_gate      (t1_gate),
    .wr_th        (wr_th),
    .wr_tl        (wr_tl),
    .flag_clr     (flag_clr),
    .irq_ack      (irq_ack),
    .th_o         (th_o),
    .tl_o         (tl_o),
    .ovf_flag_o   (ovf_flag_o),
    .baud_pulse_o (baud_pulse_o)
);

// File: tb/test_t1_split_timer.sv
`timescale 1ns/1ps
module test_t1_split_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 0, cnt_pin = 0, gate_in = 0;
    logic [1:0] t0_mode = 0, t1_mode = 0;
    logic       t1_gate = 0, t1_cnt_sel = 0, t1_run = 0;
    logic       wr_th = 0, wr_tl = 0, flag_clr = 0, irq_ack = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] th_o, tl_o;
    logic       ovf_flag_o, baud_pulse_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    t1_split_timer i_t1_split_timer (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) mc_tick = 1;
        @(negedge clk) mc_tick = 0;
    endtask

    task automatic load(input logic [7:0] th, input logic [7:0] tl);
        @(negedge clk) begin wr_th = 1; wr_data = th; end
        @(negedge clk) begin wr_th = 0; wr_tl = 1; wr_data = tl; end
        @(negedge clk) wr_tl = 0;
    endtask

    task automatic pin_pulse();
        @(negedge clk) cnt_pin = 1;
        repeat (3) @(negedge clk);
        cnt_pin = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1;
        @(negedge clk) flag_clr = 0;
    endtask

    task automatic t_reset();
        chk("R12 count", {th_o, tl_o}, 16'h0000);
        chk("R12 flags", {14'd0, ovf_flag_o, baud_pulse_o}, 16'd0);
    endtask

    task automatic t_mode16();
        t1_mode = 1; t1_run = 1;
        load(8'hFF, 8'hFE);
        chk("R11 load", {th_o, tl_o}, 16'hFFFE);
        repeat (5) @(negedge clk);
        chk("R5 no strobe", {th_o, tl_o}, 16'hFFFE);
        tick();
        chk("R2 step", {th_o, tl_o}, 16'hFFFF);
        tick();
        chk("R2 wrap", {th_o, tl_o}, 16'h0000);
        chk("R8 flag+baud", {14'd0, ovf_flag_o, baud_pulse_o}, 16'd3);
        @(negedge clk);
        chk("R8 pulse one clock", {15'd0, baud_pulse_o}, 16'd0);
        t1_run = 0;
        tick();
        chk("R5 run off", {th_o, tl_o}, 16'h0000);
        clear_flag();
        chk("R9 sw clear", {15'd0, ovf_flag_o}, 16'd0);
    endtask

    task automatic t_ack_and_win();
        t1_mode = 1; t1_run = 1;
        load(8'hFF, 8'hFF);
        tick();
        chk("R8 flag set", {15'd0, ovf_flag_o}, 16'd1);
        @(negedge clk) irq_ack = 1;
        @(negedge clk) irq_ack = 0;
        chk("R9 ack clear", {15'd0, ovf_flag_o}, 16'd0);
        load(8'hFF, 8'hFF);
        @(negedge clk) begin mc_tick = 1; irq_ack = 1; end
        @(negedge clk) begin mc_tick = 0; irq_ack = 0; end
        chk("R9 set wins", {15'd0, ovf_flag_o}, 16'd1);
        clear_flag();
    endtask

    task automatic t_mode13();
        t1_mode = 0; t1_run = 1;
        load(8'h12, 8'h1F);
        tick();
        chk("R1 carry into TH", {th_o, tl_o}, 16'h1300);
        chk("R1 no ovf", {15'd0, ovf_flag_o}, 16'd0);
        load(8'hFF, 8'hFE);
        tick();
        chk("R1 step", {th_o, tl_o}, 16'hFFFF);
        tick();
        chk("R1 wrap keeps TL[7:5]", {th_o, tl_o}, 16'h00E0);
        chk("R1 ovf", {14'd0, ovf_flag_o, baud_pulse_o}, 16'd3);
        clear_flag();
    endtask

    task automatic t_reload();
        t1_mode = 2; t1_run = 1;
        load(8'h80, 8'hFE);
        tick();
        chk("R3 step", {th_o, tl_o}, 16'h80FF);
        tick();
        chk("R3 reload", {th_o, tl_o}, 16'h8080);
        chk("R3 ovf", {14'd0, ovf_flag_o, baud_pulse_o}, 16'd3);
        clear_flag();
    endtask

    task automatic t_hold();
        t1_mode = 3; t1_run = 1;
        load(8'h44, 8'h55);
        tick(); tick();
        chk("R4 hold", {th_o, tl_o}, 16'h4455);
        t0_mode = 3;
        tick();
        chk("R4 hold in split", {th_o, tl_o}, 16'h4455);
        t0_mode = 0;
    endtask

    task automatic t_gate();
        t1_mode = 1; t1_run = 1; t1_gate = 1; gate_in = 0;
        load(8'h00, 8'h10);
        tick();
        chk("R6 gated off", {th_o, tl_o}, 16'h0010);
        gate_in = 1;
        tick();
        chk("R6 gated on", {th_o, tl_o}, 16'h0011);
        t1_gate = 0; gate_in = 0;
    endtask

    task automatic t_counter();
        t1_mode = 1; t1_run = 1; t1_cnt_sel = 1;
        load(8'h00, 8'h20);
        tick();
        chk("R7 no edge", {th_o, tl_o}, 16'h0020);
        pin_pulse();
        chk("R7 waits for strobe", {th_o, tl_o}, 16'h0020);
        tick();
        chk("R7 one edge", {th_o, tl_o}, 16'h0021);
        pin_pulse(); pin_pulse();
        tick();
        chk("R7 one per strobe", {th_o, tl_o}, 16'h0022);
        tick();
        chk("R7 consumed", {th_o, tl_o}, 16'h0022);
        t1_cnt_sel = 0;
    endtask

    task automatic t_split();
        t0_mode = 3; t1_mode = 1;
        t1_run = 0; t1_gate = 1; gate_in = 0; t1_cnt_sel = 1;
        load(8'h01, 8'h00);
        tick();
        chk("R10 counts regardless", {th_o, tl_o}, 16'h0101);
        load(8'hFF, 8'hFF);
        tick();
        chk("R10 wrap", {th_o, tl_o}, 16'h0000);
        chk("R10 baud, no flag", {14'd0, ovf_flag_o, baud_pulse_o}, 16'd1);
        t0_mode = 0; t1_gate = 0; t1_cnt_sel = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mode16();
        t_ack_and_win();
        t_mode13();
        t_reload();
        t_hold();
        t_gate();
        t_counter();
        t_split();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule